// File: doc/BRIEF.md
# Serial Transmitter with Idle Preamble

This block sends characters on an asynchronous serial line. Software writes a character into a one-entry holding register. While the transmitter is enabled, the character moves into a shift register on a baud tick. It then goes out as a start bit of zero, the data bits lowest first, and a stop bit of one. An external divider supplies a single-cycle baud tick, and each line bit lasts from one tick to the next. A format input selects 8 or 9 data bits.

Two messages can be separated by the shortest idle gap that listening receivers will accept. To do this, software drops the enable and raises it again while a character is still on the line. The transmitter finishes that character and then holds the line high for one full character time: 10 bit-times in the 8-bit format and 11 in the 9-bit format. If the holding register has been loaded by then, the next character follows directly. Otherwise the line stays high until a write arrives.

Two flags report progress. The empty flag says the holding register can take a new character. The done flag says the line has gone quiet. Each flag drives an interrupt that has its own enable. A pin-ownership output tells the pad logic when the transmitter has released the line.

Top module: `sertx_top`

## Requirements
- R1: Directly after reset, the line output is 1, the empty flag is 1, the done flag is 1, pin ownership is 0 while the enable is low, and both interrupts are 0 while their enables are low.
- R2: A character goes out as one start bit of 0, then the data bits with bit 0 first, then one stop bit of 1. The 8-bit format (format input 0) sends data_in[7:0] in 10 bit periods. The 9-bit format (format input 1) also sends data_in[8], for 11 bit periods. Each bit lasts one baud tick period.
- R3: A data write clears the empty flag. The flag sets again on the baud tick that copies the holding register into the shifter.
- R4: If the enable stays high and the holding register is full when a stop bit ends, the next start bit follows that stop bit with no idle bit-time.
- R5: Suppose the enable is seen low during a character and is high again when that character's stop bit ends. The line then stays at 1 for exactly 10 bit-times (8-bit format) or 11 bit-times (9-bit format) after the stop bit, and any waiting character starts right after that gap.
- R6: If the holding register is still empty when the preamble ends, the line stays at 1 and the empty flag stays 1 until a write arrives. The character then goes out with the normal frame.
- R7: The done flag is 0 while a character or a preamble is on the line. It is 1 once the line is quiet and either the holding register is empty or the enable is low.
- R8: Pin ownership is 1 while the enable is high or a character is on the line. When the enable is cleared during a character, ownership stays 1 until the stop bit ends and then drops to 0.
- R9: The empty interrupt equals the empty flag AND its enable. The done interrupt equals the done flag AND its enable.
- R10: While the enable is low, a written character stays in the holding register and the line stays at 1. The character is sent once the enable goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmitter enable |
| nine_bit | input | 1 | Format select: 0 = 8 data bits, 1 = 9 data bits |
| irq_en_empty | input | 1 | Enable for the empty interrupt |
| irq_en_done | input | 1 | Enable for the done interrupt |
| data_we | input | 1 | Write strobe for the holding register |
| data_in | input | 9 | Character to send |
| txd | output | 1 | Serial line output |
| pin_own | output | 1 | High while the transmitter owns the line pin |
| tdre | output | 1 | Holding register empty flag |
| tc | output | 1 | Transmission done flag |
| irq_empty | output | 1 | Gated empty interrupt |
| irq_done | output | 1 | Gated done interrupt |

## Verification
The assertions assume three things about the inputs. The baud tick is a single-cycle pulse with idle cycles between pulses. The format input changes only while the line is quiet. A data write lands on a clock cycle that is not also the copying tick. The bench meets all three: it produces the tick itself, one pulse every four clocks. It sets the format only between scenarios. It writes on falling-edge boundaries, and the only writes that can fall near a copy are writes made while the holding register is already full. Line bits are captured once per bit period, just before the tick that ends them. This lets the idle gap between two messages be counted in whole bit-times, and that count is compared exactly with 0, 10 or 11.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int DATA_W  = 9;
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_PRE   = 2'd2
    } tx_state_e;

    function automatic logic [CNT_W-1:0] frame_last(input logic nine);
        return nine ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
    endfunction

    function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                      input logic nine);
        return {1'b1, (nine ? d[DATA_W-1] : 1'b1), d[DATA_W-2:0], 1'b0};
    endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    input  logic              load_pulse,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (data_we) begin
            hold_full <= 1'b1;
            hold_data <= data_in;
        end else if (load_pulse) begin
            hold_full <= 1'b0;
        end
    end

    p_no_copy_empty_r3: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> hold_full);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              txd,
    output logic              busy,
    output logic              load_pulse
);
    tx_state_e          st;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   idx;
    logic [CNT_W-1:0]   last;
    logic               pend;
    logic               at_last;
    logic               can_load;

    always_comb begin
        last     = frame_last(nine_bit);
        at_last  = (idx == last);
        can_load = tx_en && hold_full;
        load_pulse = baud_tick && can_load &&
                     ((st == ST_IDLE) ||
                      (st == ST_FRAME && at_last && !pend) ||
                      (st == ST_PRE && at_last));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            shreg <= '1;
            idx   <= '0;
            pend  <= 1'b0;
        end else begin
            if (st == ST_FRAME && !tx_en) pend <= 1'b1;
            if (load_pulse) begin
                st    <= ST_FRAME;
                shreg <= pack_frame(hold_data, nine_bit);
                idx   <= '0;
                pend  <= 1'b0;
            end else if (baud_tick) begin
                case (st)
                    ST_FRAME: begin
                        if (at_last) begin
                            shreg <= '1;
                            idx   <= '0;
                            pend  <= 1'b0;
                            st    <= (tx_en && pend) ? ST_PRE : ST_IDLE;
                        end else begin
                            shreg <= {1'b1, shreg[FRAME_W-1:1]};
                            idx   <= idx + CNT_W'(1);
                        end
                    end
                    ST_PRE: begin
                        if (at_last) begin
                            st  <= ST_IDLE;
                            idx <= '0;
                        end else begin
                            idx <= idx + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign txd  = shreg[0];
    assign busy = (st != ST_IDLE);

    p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FRAME && at_last) |-> txd);
    p_pre_high_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PRE) |-> txd);
    p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> txd);
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !txd);
    p_no_start_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> tx_en);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              irq_en_empty,
    input  logic              irq_en_done,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    output logic              txd,
    output logic              pin_own,
    output logic              tdre,
    output logic              tc,
    output logic              irq_empty,
    output logic              irq_done
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic              load_pulse;

    sertx_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .data_we    (data_we),
        .data_in    (data_in),
        .load_pulse (load_pulse),
        .hold_full  (hold_full),
        .hold_data  (hold_data)
    );

    sertx_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .tx_en      (tx_en),
        .nine_bit   (nine_bit),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .txd        (txd),
        .busy       (busy),
        .load_pulse (load_pulse)
    );

    always_comb begin
        tdre      = !hold_full;
        tc        = !busy && (!hold_full || !tx_en);
        pin_own   = tx_en || busy;
        irq_empty = tdre && irq_en_empty;
        irq_done  = tc && irq_en_done;
    end

    p_copy_empties_r3: assert property (@(posedge clk) disable iff (rst)
        (load_pulse && !data_we) |=> tdre);
    p_write_fills_r3: assert property (@(posedge clk) disable iff (rst)
        data_we |=> !tdre);
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        tc |-> txd);
    p_release_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !pin_own |-> txd);
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_empty) |-> irq_en_empty);
endmodule

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       irq_en_empty = 1'b0;
    logic       irq_en_done = 1'b0;
    logic       data_we = 1'b0;
    logic [8:0] data_in = '0;
    logic       txd, pin_own, tdre, tc, irq_empty, irq_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit wd_hit  = 1'b0;

    logic cap [0:255];
    int   cap_n = 0;
    logic cap_en = 1'b0;
    logic cap_clr = 1'b0;
    int   tick_cnt = 0;

    always #10 clk = ~clk;

    sertx_top dut_i (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
        .nine_bit(nine_bit), .irq_en_empty(irq_en_empty), .irq_en_done(irq_en_done),
        .data_we(data_we), .data_in(data_in), .txd(txd), .pin_own(pin_own),
        .tdre(tdre), .tc(tc), .irq_empty(irq_empty), .irq_done(irq_done)
    );

    always @(posedge clk) begin
        tick_cnt  <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == 3);
    end

    always @(negedge clk) begin
        if (cap_clr) cap_n = 0;
        else if (cap_en && baud_tick && cap_n < 256) begin
            cap[cap_n] = txd;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic write_data(input logic [8:0] d);
        @(negedge clk);
        data_in = d;
        data_we = 1'b1;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic wait_tdre();
        int k = 0;
        while (!tdre && k < 4000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic cap_start();
        @(posedge clk);
        cap_clr = 1'b1;
        @(posedge clk);
        cap_clr = 1'b0;
        cap_en  = 1'b1;
        @(negedge clk);
    endtask

    function automatic int first_zero(input int from);
        for (int i = from; i < cap_n; i++) if (cap[i] == 1'b0) return i;
        return -1;
    endfunction

    task automatic check_frame(input int s, input bit nine, input logic [8:0] d, input string tag);
        int   len = nine ? 11 : 10;
        int   nd  = nine ? 9 : 8;
        int   bad = 0;
        logic e;
        if (s < 0 || s + len > cap_n) begin
            chk(1'b0, tag, s, len);
            return;
        end
        for (int i = 0; i < len; i++) begin
            if (i == 0) e = 1'b0;
            else if (i <= nd) e = d[i-1];
            else e = 1'b1;
            if (cap[s+i] !== e) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic run_pair(input bit nine, input bit toggle, input bit late,
                            input logic [8:0] d1, input logic [8:0] d2, input string tag);
        int len = nine ? 11 : 10;
        int s, j, gap;
        nine_bit = nine;
        tx_en    = 1'b1;
        cap_start();
        write_data(d1);
        wait_tdre();
        if (toggle) begin
            tx_en = 1'b0;
            repeat (2) @(negedge clk);
            tx_en = 1'b1;
        end
        if (late) begin
            wait_ticks(2 * len + 4);
            chk(txd == 1'b1 && tdre == 1'b1, {tag, " R6 line idle, empty set"}, txd, 1);
        end
        write_data(d2);
        if (toggle && !late) begin
            wait_ticks(len + 2);
            chk(tc == 1'b0 && tdre == 1'b0, {tag, " R7 done low in preamble"}, tc, 0);
        end
        wait_tdre();
        wait_ticks(len + 2);
        cap_en = 1'b0;
        s = first_zero(0);
        check_frame(s, nine, d1, {tag, " R2 first frame"});
        j = s + len;
        gap = 0;
        while (j < cap_n && cap[j] == 1'b1) begin
            j++;
            gap++;
        end
        if (late) chk(gap > len, {tag, " R6 gap"}, gap, len + 1);
        else if (toggle) chk(gap == len, {tag, " R5 preamble gap"}, gap, len);
        else chk(gap == 0, {tag, " R4 back-to-back gap"}, gap, 0);
        check_frame(j, nine, d2, {tag, " R2 second frame"});
    endtask

    task automatic t_reset();
        chk(txd == 1 && tdre == 1 && tc == 1, "R1 reset line/flags", {txd, tdre, tc}, 7);
        chk(pin_own == 0 && irq_empty == 0 && irq_done == 0, "R1 reset pin/irq",
            {pin_own, irq_empty, irq_done}, 0);
    endtask

    task automatic t_disable();
        nine_bit = 1'b0;
        tx_en    = 1'b1;
        write_data(9'h03C);
        wait_tdre();
        wait_ticks(2);
        chk(tc == 0 && pin_own == 1, "R7 done low while sending", tc, 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk(pin_own == 1, "R8 ownership kept mid-frame", pin_own, 1);
        wait_ticks(12);
        chk(tc == 1 && txd == 1, "R7 done after stop bit", tc, 1);
        chk(pin_own == 0, "R8 ownership released", pin_own, 0);
    endtask

    task automatic t_held();
        nine_bit = 1'b1;
        tx_en    = 1'b0;
        cap_start();
        write_data(9'h1A5);
        wait_ticks(5);
        chk(tdre == 0 && txd == 1, "R10 held while disabled", tdre, 0);
        chk(pin_own == 0, "R10 no ownership while disabled", pin_own, 0);
        tx_en = 1'b1;
        wait_tdre();
        wait_ticks(13);
        cap_en = 1'b0;
        check_frame(first_zero(0), 1'b1, 9'h1A5, "R10 frame after enable");
    endtask

    task automatic t_irq();
        irq_en_empty = 1'b1;
        @(negedge clk);
        chk(irq_empty == 1 && irq_done == 0, "R9 empty irq gated on", irq_empty, 1);
        irq_en_done = 1'b1;
        @(negedge clk);
        chk(irq_done == 1, "R9 done irq gated on", irq_done, 1);
        irq_en_empty = 1'b0;
        @(negedge clk);
        chk(irq_empty == 0, "R9 empty irq masked", irq_empty, 0);
        irq_en_empty = 1'b1;
        nine_bit = 1'b0;
        tx_en    = 1'b1;
        write_data(9'h055);
        chk(irq_empty == 0 && tdre == 0, "R3 write clears empty", tdre, 0);
        wait_tdre();
        chk(tdre == 1 && irq_empty == 1, "R3 copy sets empty", tdre, 1);
        wait_ticks(2);
        chk(irq_done == 0, "R9 done irq low while sending", irq_done, 0);
        wait_ticks(12);
        irq_en_empty = 1'b0;
        irq_en_done  = 1'b0;
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_pair(1'b0, 1'b1, 1'b0, 9'h0A3, 9'h05C, "8bit toggle");
        run_pair(1'b1, 1'b1, 1'b0, 9'h135, 9'h0CA, "9bit toggle");
        run_pair(1'b0, 1'b0, 1'b0, 9'h0F0, 9'h00F, "8bit plain");
        run_pair(1'b1, 1'b0, 1'b0, 9'h1FF, 9'h100, "9bit plain");
        run_pair(1'b0, 1'b1, 1'b1, 9'h081, 9'h07E, "8bit late");
        t_disable();
        t_held();
        t_irq();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        if (wd_hit) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule